// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This block takes two IEEE-754 operands, in either single or double precision, and evaluates one of eight relational predicates on them. The result is a single condition flag. A quiet comparison is made. NaN operands produce the unordered relation. An invalid-operation indication is raised only when a signalling NaN is present.

The flag is also merged into a 32-bit status word that the caller supplies with the request. The flag goes into bit 29, the remaining bits of the top nibble are forced to zero, and bits 27:0 pass through unchanged. A request is made by pulsing `in_valid` with the operands, the precision select, the predicate code and the current status word. The result appears one clock later, together with `out_valid`.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset is released, `out_valid`, `cond_flag`, `invalid_op` and `status_out` are all zero.
- R2: A request accepted on a clock edge with `in_valid` high is presented on the next edge, with `out_valid` high for exactly that one cycle. While `in_valid` is low, `cond_flag`, `invalid_op` and `status_out` hold their values.
- R3: Predicate codes map as follows: 0 is always false; 1 is unordered; 2 is equal; 3 is equal or unordered; 4 is ordered less-than; 5 is less-than or unordered; 6 is ordered less-or-equal; 7 is anything but greater-than, which includes unordered.
- R4: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. A NaN in either operand gives the unordered relation.
- R5: A NaN whose most significant fraction bit is 0 is signalling. `invalid_op` is 1 exactly when at least one operand is a signalling NaN. Quiet NaNs never raise it.
- R6: +0 and -0 compare as equal, in both precisions.
- R7: `status_out[29]` equals `cond_flag`, bits 31, 30 and 28 are 0, and bits 27:0 equal `status_in[27:0]` of the accepted request.
- R8: When `dbl_sel` is 1, the full 64-bit operands are compared as double precision. When it is 0, only `opnd_a[31:0]` and `opnd_b[31:0]` are compared as single precision, and the upper 32 bits have no effect.
- R9: Only `pred_code[2:0]` selects the predicate. `pred_code[3]` has no effect.
- R10: Ordered operands, including infinities and subnormals, are ranked by their real value. A value with the sign bit set ranks below one with the sign bit clear, except that two zeros compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | First operand (single precision in bits 31:0) |
| opnd_b | input | 64 | Second operand (single precision in bits 31:0) |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single |
| pred_code | input | 4 | Predicate selector, low three bits used |
| status_in | input | 32 | Status word to merge the flag into |
| out_valid | output | 1 | Result valid, one cycle after the request |
| cond_flag | output | 1 | Predicate result |
| status_out | output | 32 | Merged status word |
| invalid_op | output | 1 | Signalling NaN seen on an operand |

## Verification
On every cycle, the assertions check the one-cycle latency of `out_valid`, that the status word shape holds the flag at bit 29 with a cleared nibble, that the low bits are passed through, that code 0 gives false, that the inclusive codes are true on their relations, that quiet operands raise no invalid indication, and that outputs hold between requests. Whether the flag is correct for real operand values can only be shown by the bench's scenarios. These cover ordering across signs, infinities and subnormals, equal signed zeros, NaN classification, and the fact that the upper operand bits and the spare predicate bit are ignored. The bench sweeps every pair from a set of twelve special and ordinary values, over all eight codes and both precisions.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MAG_W  = 63,
  localparam int OP_W  = EXP_W + FRAC_W + 1
) (
  input  logic [OP_W-1:0]  operand,
  output logic             sign,
  output logic             is_nan,
  output logic             is_snan,
  output logic             is_zero,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    sign    = operand[OP_W-1];
    exp_f   = operand[OP_W-2 -: EXP_W];
    frac_f  = operand[FRAC_W-1:0];
    is_nan  = (&exp_f) && (|frac_f);
    is_snan = is_nan && !frac_f[FRAC_W-1];
    is_zero = ~|operand[OP_W-2:0];
    mag     = '0;
    mag[OP_W-2:0] = operand[OP_W-2:0];
  end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_a,
  input  logic             nan_b,
  input  logic             zero_a,
  input  logic             zero_b,
  output rel_t             rel
);
  logic mag_lt;

  always_comb begin
    mag_lt = (mag_a < mag_b);
    if (nan_a || nan_b)           rel = REL_UN;
    else if (zero_a && zero_b)    rel = REL_EQ;
    else if (sign_a != sign_b)    rel = sign_a ? REL_LT : REL_GT;
    else if (mag_a == mag_b)      rel = REL_EQ;
    else if (mag_lt ^ sign_a)     rel = REL_LT;
    else                          rel = REL_GT;
  end
endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
  import fpcmp_pkg::*;
(
  input  rel_t       rel,
  input  logic [2:0] code,
  output logic       flag
);
  // code bit 0 admits unordered, bit 1 admits equal, bit 2 admits less-than
  always_comb begin
    flag = (code[0] && rel == REL_UN) ||
           (code[1] && rel == REL_EQ) ||
           (code[2] && rel == REL_LT);
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  parameter int PRED_IN_W = 4,
  parameter int STAT_W    = 32,
  parameter int FLAG_POS  = 29,
  parameter int KEEP_W    = 28,
  localparam int OP_W     = DP_EXP_W + DP_FRAC_W + 1,
  localparam int SP_W     = SP_EXP_W + SP_FRAC_W + 1,
  localparam int MAG_W    = OP_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      opnd_a,
  input  logic [OP_W-1:0]      opnd_b,
  input  logic                 dbl_sel,
  input  logic [PRED_IN_W-1:0] pred_code,
  input  logic [STAT_W-1:0]    status_in,
  output logic                 out_valid,
  output logic                 cond_flag,
  output logic [STAT_W-1:0]    status_out,
  output logic                 invalid_op
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [OP_W-1:0] opnd [2];
  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  logic             sp_sign [2], dp_sign [2], sel_sign [2];
  logic             sp_nan  [2], dp_nan  [2], sel_nan  [2];
  logic             sp_snan [2], dp_snan [2], sel_snan [2];
  logic             sp_zero [2], dp_zero [2], sel_zero [2];
  logic [MAG_W-1:0] sp_mag  [2], dp_mag  [2], sel_mag  [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    fpcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .MAG_W(MAG_W)) u_sp (
      .operand (opnd[gi][SP_W-1:0]),
      .sign    (sp_sign[gi]),
      .is_nan  (sp_nan[gi]),
      .is_snan (sp_snan[gi]),
      .is_zero (sp_zero[gi]),
      .mag     (sp_mag[gi])
    );
    fpcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .MAG_W(MAG_W)) u_dp (
      .operand (opnd[gi]),
      .sign    (dp_sign[gi]),
      .is_nan  (dp_nan[gi]),
      .is_snan (dp_snan[gi]),
      .is_zero (dp_zero[gi]),
      .mag     (dp_mag[gi])
    );
    always_comb begin
      sel_sign[gi] = dbl_sel ? dp_sign[gi] : sp_sign[gi];
      sel_nan[gi]  = dbl_sel ? dp_nan[gi]  : sp_nan[gi];
      sel_snan[gi] = dbl_sel ? dp_snan[gi] : sp_snan[gi];
      sel_zero[gi] = dbl_sel ? dp_zero[gi] : sp_zero[gi];
      sel_mag[gi]  = dbl_sel ? dp_mag[gi]  : sp_mag[gi];
    end
  end

  rel_t rel;
  fpcmp_relate #(.MAG_W(MAG_W)) u_relate (
    .sign_a (sel_sign[0]),
    .sign_b (sel_sign[1]),
    .mag_a  (sel_mag[0]),
    .mag_b  (sel_mag[1]),
    .nan_a  (sel_nan[0]),
    .nan_b  (sel_nan[1]),
    .zero_a (sel_zero[0]),
    .zero_b (sel_zero[1]),
    .rel    (rel)
  );

  logic flag_d;
  fpcmp_predicate u_pred (
    .rel  (rel),
    .code (pred_code[2:0]),
    .flag (flag_d)
  );

  logic unused_pred_hi;
  assign unused_pred_hi = ^pred_code[PRED_IN_W-1:3];

  // next-state
  logic [STAT_W-1:0] status_d;
  logic              invalid_d;

  always_comb begin
    status_d               = '0;
    status_d[KEEP_W-1:0]   = status_in[KEEP_W-1:0];
    status_d[FLAG_POS]     = flag_d;
    invalid_d              = sel_snan[0] || sel_snan[1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cond_flag  <= 1'b0;
      status_out <= '0;
      invalid_op <= 1'b0;
    end else if (in_valid) begin
      cond_flag  <= flag_d;
      status_out <= status_d;
      invalid_op <= invalid_d;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(cond_flag) && $stable(status_out) && $stable(invalid_op)); // R2
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (status_out[FLAG_POS] == cond_flag) && !status_out[31] &&
                  !status_out[30] && !status_out[28]); // R7
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> status_out[KEEP_W-1:0] == $past(status_in[KEEP_W-1:0])); // R7
  AST_CODE0_FALSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && pred_code[2:0] == 3'd0) |=> !cond_flag); // R3
  AST_CODE7_NOT_GT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && pred_code[2:0] == 3'd7 && rel != REL_GT) |=> cond_flag); // R3
  AST_UNORD_CODE1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && pred_code[2:0] == 3'd1 && (sel_nan[0] || sel_nan[1])) |=> cond_flag); // R4
  AST_QUIET_NO_INV: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !sel_snan[0] && !sel_snan[1]) |=> !invalid_op); // R5
endmodule

// File: tb/fpcmp_unit_tb.sv
module fpcmp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] opnd_a, opnd_b;
  logic        dbl_sel;
  logic [3:0]  pred_code;
  logic [31:0] status_in;
  logic        out_valid, cond_flag, invalid_op;
  logic [31:0] status_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fpcmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .dbl_sel(dbl_sel),
    .pred_code(pred_code), .status_in(status_in),
    .out_valid(out_valid), .cond_flag(cond_flag),
    .status_out(status_out), .invalid_op(invalid_op)
  );

  // 0 -inf, 1 -2, 2 -1, 3 -0, 4 +0, 5 min subnormal, 6 1, 7 1.5, 8 2, 9 +inf, 10 qNaN, 11 sNaN
  function automatic logic [63:0] val(bit dbl, int k);
    if (dbl) begin
      case (k)
        0: return 64'hFFF0_0000_0000_0000;  1: return 64'hC000_0000_0000_0000;
        2: return 64'hBFF0_0000_0000_0000;  3: return 64'h8000_0000_0000_0000;
        4: return 64'h0;                    5: return 64'h1;
        6: return 64'h3FF0_0000_0000_0000;  7: return 64'h3FF8_0000_0000_0000;
        8: return 64'h4000_0000_0000_0000;  9: return 64'h7FF0_0000_0000_0000;
        10: return 64'h7FF8_0000_0000_0000; default: return 64'h7FF0_0000_0000_0001;
      endcase
    end else begin
      case (k)
        0: return 64'hFF80_0000;  1: return 64'hC000_0000;  2: return 64'hBF80_0000;
        3: return 64'h8000_0000;  4: return 64'h0;          5: return 64'h1;
        6: return 64'h3F80_0000;  7: return 64'h3FC0_0000;  8: return 64'h4000_0000;
        9: return 64'h7F80_0000;  10: return 64'h7FC0_0000; default: return 64'h7F80_0001;
      endcase
    end
  endfunction

  function automatic int rank(int k);
    if (k <= 3) return k;   // -0 and +0 share rank 3 (R6)
    return k - 1;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmp(bit dbl, int ka, int kb, int code, bit hold_chk);
    bit un, lt, eq, gt, exp_flag, exp_inv;
    logic [31:0] st, exp_st;
    st = $urandom;
    un = (ka >= 10) || (kb >= 10);
    lt = !un && rank(ka) < rank(kb);
    eq = !un && rank(ka) == rank(kb);
    gt = !un && rank(ka) > rank(kb);
    case (code)
      0: exp_flag = 1'b0;
      1: exp_flag = un;
      2: exp_flag = eq;
      3: exp_flag = eq || un;
      4: exp_flag = lt;
      5: exp_flag = lt || un;
      6: exp_flag = lt || eq;
      default: exp_flag = !gt;
    endcase
    exp_inv = (ka == 11) || (kb == 11);
    exp_st  = {2'b00, exp_flag, 1'b0, st[27:0]};
    @(negedge clk);
    in_valid  = 1'b1;
    dbl_sel   = dbl;
    // R8: junk in upper half for single; R9: random spare predicate bit
    opnd_a    = dbl ? val(1, ka) : {$urandom, val(0, ka)[31:0]};
    opnd_b    = dbl ? val(1, kb) : {$urandom, val(0, kb)[31:0]};
    pred_code = {1'($urandom), 3'(code)};
    status_in = st;
    @(negedge clk);
    in_valid  = 1'b0;
    opnd_a    = $urandom;
    status_in = $urandom;
    check(out_valid == 1'b1, "R2 out_valid", 64'(out_valid), 64'd1);
    check(cond_flag == exp_flag, "R3 R4 R6 R8 R9 R10 cond_flag", 64'(cond_flag), 64'(exp_flag));
    check(invalid_op == exp_inv, "R5 invalid_op", 64'(invalid_op), 64'(exp_inv));
    check(status_out == exp_st, "R7 status_out", 64'(status_out), 64'(exp_st));
    if (hold_chk) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2 valid pulse", 64'(out_valid), 64'd0);
      check(cond_flag == exp_flag && status_out == exp_st, "R2 hold",
            64'(status_out), 64'(exp_st));
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opnd_a = '0; opnd_b = '0;
    dbl_sel = 1'b0; pred_code = '0; status_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && cond_flag == 1'b0 && invalid_op == 1'b0 && status_out == '0,
          "R1 reset state", 64'(status_out), 64'd0);
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 12; a++)
        for (int b = 0; b < 12; b++)
          for (int c = 0; c < 8; c++)
            run_cmp(d[0], a, b, c, (b == 0 && c == 7));
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule